// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Controller with Wake-Up Sequencing

This block sits between a synchronous host and a 4M x 4 asynchronous DRAM whose row and column addresses share one multiplexed bus. The host hands it single reads and writes over a valid/ready handshake. The controller turns each request into a timed sequence of the active-low row strobe, column strobe, write enable and output enable. All timing is counted in clock cycles and set by parameters.

Before any access, the controller waits out a power-up pause. It then runs a fixed number of wake-up refresh cycles and only afterwards opens the host port. A down-counter raises a refresh request at a fixed interval. That request is served with a column-before-row refresh, with write enable held high so that the device never sees a test-mode entry. Refresh always wins over a host request that has not yet started.

If a refresh request waits longer than a grace window, the refresh deadline counts as broken. The controller then runs the full wake-up sequence again before it accepts new host work. Writes are always early writes. A read returns its data with a one-cycle valid pulse.

Top module: `adram_ctl`

## Requirements
- R1: During reset and for at least PAUSE_CYC clocks after reset is released, ras_n_o, cas_n_o, we_n_o and oe_n_o stay high, req_ready_o stays low, and the row strobe never falls.
- R2: After the pause, exactly WAKE_N refresh cycles are performed before req_ready_o is high for the first time.
- R3: In every refresh cycle the column strobe is low when the row strobe falls, and we_n_o and oe_n_o are both high at that moment.
- R4: A write is an early write. we_n_o goes low before the row strobe falls and stays low through the column-strobe fall, oe_n_o stays high, and mem_dq_o carries the host data while mem_dq_oe_o is high.
- R5: A read holds we_n_o high and drives oe_n_o low while the column strobe is low. It samples mem_dq_i T_CAP clocks after the column strobe falls and presents the value on rd_data_o with a single-cycle rd_valid_o pulse.
- R6: The row strobe stays high for at least T_RP clocks between any two low periods, back-to-back refresh cycles included.
- R7: req_ready_o is high only while both strobes are high and the precharge of the last cycle has run T_RP clocks.
- R8: A refresh request is raised every REF_INT clocks once the pause has ended. It stays pending until it is served and is taken before any waiting host request, so continuous host traffic cannot starve refresh.
- R9: If a refresh request stays pending for REF_GRACE clocks, the controller runs WAKE_N back-to-back refresh cycles before it serves the host again.
- R10: The row part of the address, req_addr_i[21:11], is on mem_addr_o when the row strobe falls. The column part, req_addr_i[10:0], is on mem_addr_o when the column strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Row (upper 11) and column (lower 11) address |
| req_wdata_i | input | 4 | Write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 4 | Read data |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| mem_addr_o | output | 11 | Multiplexed DRAM address |
| mem_dq_o | output | 4 | Data toward the DRAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 4 | Data from the DRAM |

## Verification
The collision that matters is a refresh-timer expiry that lands in the same idle cycle as a host request that is held valid. The bench provokes it by keeping req_valid_i high for several refresh intervals, so that every expiry meets a waiting read. It judges the result by counting refresh cycles in that window, which should match the interval, and by confirming that no wake-up burst occurs. A second instance with a one-clock grace window makes the same collision break the deadline on purpose, and there the bench expects a run of WAKE_N back-to-back refreshes.

// File: rtl/adram_pkg.sv
package adram_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_ROW,
    ST_RASL,
    ST_COL,
    ST_CASL,
    ST_CBRC,
    ST_CBRR
  } adram_state_e;

endpackage

// File: rtl/adram_wake.sv
module adram_wake #(
  parameter int unsigned PAUSE_CYC = 12500,
  parameter int unsigned WAKE_N    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cbr_start_i,
  input  logic miss_i,
  output logic pause_done_o,
  output logic wake_busy_o
);

  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned WW = $clog2(WAKE_N + 1);

  logic [PW-1:0] pause_q;
  logic [WW-1:0] left_q;

  assign pause_done_o = (pause_q == PW'(PAUSE_CYC));
  assign wake_busy_o  = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pause_q <= '0;
    else if (!pause_done_o) pause_q <= pause_q + 1'b1;
  end

  // reload on a broken deadline, else count served wake cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= WW'(WAKE_N);
    else if (miss_i) left_q <= WW'(WAKE_N);
    else if (cbr_start_i && wake_busy_o) left_q <= left_q - 1'b1;
  end

  // R9
  wake_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> wake_busy_o);

endmodule

// File: rtl/adram_refresh.sv
module adram_refresh #(
  parameter int unsigned REF_INT   = 1953,
  parameter int unsigned REF_GRACE = 1953
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic svc_i,
  output logic pend_o,
  output logic miss_o
);

  localparam int unsigned TW = $clog2(REF_INT + 1);
  localparam int unsigned GW = $clog2(REF_GRACE + 2);

  logic [TW-1:0] tmr_q;
  logic [GW-1:0] age_q;
  logic          fire;

  assign fire   = en_i && (tmr_q == '0);
  assign miss_o = pend_o && !svc_i && (age_q == GW'(REF_GRACE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= TW'(REF_INT - 1);
    else if (en_i) tmr_q <= fire ? TW'(REF_INT - 1) : tmr_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      age_q  <= '0;
    end else if (fire) begin
      pend_o <= 1'b1;
      if (svc_i || !pend_o) age_q <= '0;
    end else if (svc_i) begin
      pend_o <= 1'b0;
      age_q  <= '0;
    end else if (pend_o && age_q != GW'(REF_GRACE + 1)) begin
      age_q <= age_q + 1'b1;
    end
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !svc_i |=> pend_o);

endmodule

// File: rtl/adram_ctl.sv
module adram_ctl #(
  parameter int unsigned ROW_W     = 11,
  parameter int unsigned COL_W     = 11,
  parameter int unsigned DQ_W      = 4,
  parameter int unsigned PAUSE_CYC = 12500,
  parameter int unsigned WAKE_N    = 8,
  parameter int unsigned REF_INT   = 1953,
  parameter int unsigned REF_GRACE = 1953,
  parameter int unsigned T_RP      = 6,
  parameter int unsigned T_RAH     = 1,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_CAS     = 4,
  parameter int unsigned T_CAP     = 3,
  parameter int unsigned T_CSR     = 1,
  parameter int unsigned T_RAS     = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_we_i,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DQ_W-1:0]        req_wdata_i,
  output logic                   rd_valid_o,
  output logic [DQ_W-1:0]        rd_data_o,
  output logic                   ras_n_o,
  output logic                   cas_n_o,
  output logic                   we_n_o,
  output logic                   oe_n_o,
  output logic [ROW_W-1:0]       mem_addr_o,
  output logic [DQ_W-1:0]        mem_dq_o,
  output logic                   mem_dq_oe_o,
  input  logic [DQ_W-1:0]        mem_dq_i
);
  import adram_pkg::*;

  localparam int unsigned AW    = ROW_W + COL_W;
  localparam int unsigned CNT_W = $clog2(T_RAS + T_CAS + T_RCD + T_CSR + 2);
  localparam int unsigned PRE_W = $clog2(T_RP + 1);

  adram_state_e      state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic              lat_we_q;
  logic [AW-1:0]     lat_addr_q;
  logic [DQ_W-1:0]   lat_data_q;

  logic pause_done, wake_busy, ref_pend, ref_miss;
  logic ref_need, slot_free, cbr_start, fire, in_acc;

  assign ref_need  = wake_busy || ref_pend;
  assign slot_free = (state_q == ST_IDLE) && (pre_q == '0);
  assign cbr_start = slot_free && ref_need;
  assign req_ready_o = slot_free && !ref_need;
  assign fire      = req_ready_o && req_valid_i;
  assign in_acc    = state_q inside {ST_ROW, ST_RASL, ST_COL, ST_CASL};

  adram_wake #(.PAUSE_CYC(PAUSE_CYC), .WAKE_N(WAKE_N)) u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cbr_start_i (cbr_start),
    .miss_i      (ref_miss),
    .pause_done_o(pause_done),
    .wake_busy_o (wake_busy)
  );

  adram_refresh #(.REF_INT(REF_INT), .REF_GRACE(REF_GRACE)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pause_done),
    .svc_i (cbr_start),
    .pend_o(ref_pend),
    .miss_o(ref_miss)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PAUSE;
      cnt_q      <= '0;
      pre_q      <= '0;
      lat_we_q   <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      if (state_q == ST_IDLE && pre_q != '0) pre_q <= pre_q - 1'b1;
      unique case (state_q)
        ST_PAUSE: if (pause_done) state_q <= ST_IDLE;
        ST_IDLE: begin
          if (cbr_start) begin
            state_q <= ST_CBRC;
            cnt_q   <= '0;
          end else if (fire) begin
            state_q    <= ST_ROW;
            lat_we_q   <= req_we_i;
            lat_addr_q <= req_addr_i;
            lat_data_q <= req_wdata_i;
          end
        end
        ST_ROW: begin
          state_q <= ST_RASL;
          cnt_q   <= '0;
        end
        ST_RASL: begin
          if (cnt_q == CNT_W'(T_RAH - 1)) begin
            state_q <= ST_COL;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_COL: begin
          if (cnt_q == CNT_W'(T_RCD - T_RAH - 1)) begin
            state_q <= ST_CASL;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_CASL: begin
          if (!lat_we_q && cnt_q == CNT_W'(T_CAP - 1)) begin
            rd_data_o  <= mem_dq_i;
            rd_valid_o <= 1'b1;
          end
          if (cnt_q == CNT_W'(T_CAS - 1)) begin
            state_q <= ST_IDLE;
            pre_q   <= PRE_W'(T_RP);
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_CBRC: begin
          if (cnt_q == CNT_W'(T_CSR - 1)) begin
            state_q <= ST_CBRR;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_CBRR: begin
          if (cnt_q == CNT_W'(T_RAS - 1)) begin
            state_q <= ST_IDLE;
            pre_q   <= PRE_W'(T_RP);
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ras_n_o     = !(state_q inside {ST_RASL, ST_COL, ST_CASL, ST_CBRR});
    cas_n_o     = !(state_q inside {ST_CASL, ST_CBRC, ST_CBRR});
    we_n_o      = !(lat_we_q && in_acc);
    oe_n_o      = !(!lat_we_q && state_q == ST_CASL);
    mem_dq_oe_o = lat_we_q && in_acc;
    mem_dq_o    = lat_data_q;
    mem_addr_o  = '0;
    if (state_q inside {ST_COL, ST_CASL})
      mem_addr_o[COL_W-1:0] = lat_addr_q[COL_W-1:0];
    else
      mem_addr_o = lat_addr_q[AW-1:COL_W];
  end

  // checker state: clocks the row strobe has been high
  logic [PRE_W:0] ras_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ras_hi_q <= '0;
    else if (!ras_n_o) ras_hi_q <= '0;
    else if (ras_hi_q != (PRE_W+1)'(T_RP + 1)) ras_hi_q <= ras_hi_q + 1'b1;
  end

  // R3
  cbr_we_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) && !cas_n_o |-> we_n_o && oe_n_o);

  // R6
  ras_precharge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> ras_hi_q >= (PRE_W+1)'(T_RP));

  // R4
  early_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) && !ras_n_o && !we_n_o |-> $past(!we_n_o) && oe_n_o);

  // R5
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  // R7
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> ras_n_o && cas_n_o);

endmodule

// File: tb/sim_adram_ctl.sv
module sim_dram_model #(
  parameter int T_RP  = 3,
  parameter int T_CSR = 1
) (
  input  logic        clk_i,
  input  logic        arm_i,
  input  logic        ready_i,
  input  logic        ras_n_i,
  input  logic        cas_n_i,
  input  logic        we_n_i,
  input  logic        oe_n_i,
  input  logic [10:0] addr_i,
  input  logic [3:0]  dq_i,
  input  logic        dq_oe_i,
  output logic [3:0]  dq_o
);
  logic [3:0]  mem [256];
  logic [10:0] row = '0;
  logic [10:0] col = '0;
  logic p_ras = 1'b1, p_cas = 1'b1, early = 1'b0, last_cbr = 1'b0, any_fall = 1'b0;
  int cyc = 0, hi_len = 0, first_fall = 0, run = 0, max_run = 0;
  int cbr_cnt = 0, acc_cnt = 0, we_err = 0, wcs_err = 0, oe_err = 0, trp_err = 0, rdy_err = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 4'h0;

  assign dq_o = (!cas_n_i && !oe_n_i && we_n_i) ? mem[{row[3:0], col[3:0]}] : 4'h0;

  always @(negedge clk_i) begin
    int nrun;
    cyc <= cyc + 1;
    if (ready_i && (!ras_n_i || !cas_n_i || hi_len + 1 < T_RP)) rdy_err <= rdy_err + 1;
    if (ras_n_i) hi_len <= hi_len + 1;
    if (p_ras && !ras_n_i) begin
      if (!any_fall) begin any_fall <= 1'b1; first_fall <= cyc; end
      if (any_fall && hi_len < T_RP) trp_err <= trp_err + 1;
      hi_len <= 0;
      if (!cas_n_i) begin
        cbr_cnt <= cbr_cnt + 1;
        if (!we_n_i || !oe_n_i) we_err <= we_err + 1;
        nrun = (last_cbr && hi_len <= T_RP + T_CSR + 3) ? run + 1 : 1;
        run <= nrun;
        if (arm_i && nrun > max_run) max_run <= nrun;
        last_cbr <= 1'b1;
      end else begin
        row <= addr_i;
        early <= !we_n_i;
        last_cbr <= 1'b0;
        run <= 0;
        acc_cnt <= acc_cnt + 1;
      end
    end
    if (p_cas && !cas_n_i && !ras_n_i) begin
      col <= addr_i;
      if (!we_n_i) begin
        if (!early) wcs_err <= wcs_err + 1;
        if (!oe_n_i) oe_err <= oe_err + 1;
        if (dq_oe_i) mem[{row[3:0], addr_i[3:0]}] <= dq_i;
      end
    end
    p_ras <= ras_n_i;
    p_cas <= cas_n_i;
  end
endmodule

module sim_adram_ctl;
  localparam int PAUSE = 40;
  localparam int WAKE  = 8;
  localparam int RINT  = 300;
  localparam int TRP   = 3;
  localparam int TCSR  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        v = 1'b0, w = 1'b0, arm = 1'b0;
  logic [21:0] a = '0;
  logic [3:0]  wd = '0;
  logic        rdy, rv, ras, cas, wen, oen, dqoe;
  logic [3:0]  rd, dqo, dqi;
  logic [10:0] ma;

  adram_ctl #(.PAUSE_CYC(PAUSE), .WAKE_N(WAKE), .REF_INT(RINT), .REF_GRACE(RINT),
              .T_RP(TRP), .T_RAH(1), .T_RCD(3), .T_CAS(3), .T_CAP(2), .T_CSR(TCSR), .T_RAS(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_ready_o(rdy), .req_we_i(w),
    .req_addr_i(a), .req_wdata_i(wd), .rd_valid_o(rv), .rd_data_o(rd),
    .ras_n_o(ras), .cas_n_o(cas), .we_n_o(wen), .oe_n_o(oen), .mem_addr_o(ma),
    .mem_dq_o(dqo), .mem_dq_oe_o(dqoe), .mem_dq_i(dqi));

  sim_dram_model #(.T_RP(TRP), .T_CSR(TCSR)) m0 (
    .clk_i(clk), .arm_i(arm), .ready_i(rdy), .ras_n_i(ras), .cas_n_i(cas), .we_n_i(wen),
    .oe_n_i(oen), .addr_i(ma), .dq_i(dqo), .dq_oe_i(dqoe), .dq_o(dqi));

  // second instance: one-clock grace so a refresh meeting a busy cycle breaks the deadline
  logic        rdy1, rv1, ras1, cas1, wen1, oen1, dqoe1, arm1;
  logic [3:0]  rd1, dqo1, dqi1;
  logic [10:0] ma1;

  assign arm1 = rdy1 || m1.acc_cnt > 0;

  adram_ctl #(.PAUSE_CYC(PAUSE), .WAKE_N(WAKE), .REF_INT(RINT), .REF_GRACE(1),
              .T_RP(TRP), .T_RAH(1), .T_RCD(3), .T_CAS(3), .T_CAP(2), .T_CSR(TCSR), .T_RAS(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(1'b1), .req_ready_o(rdy1), .req_we_i(1'b0),
    .req_addr_i(22'h000123), .req_wdata_i(4'h0), .rd_valid_o(rv1), .rd_data_o(rd1),
    .ras_n_o(ras1), .cas_n_o(cas1), .we_n_o(wen1), .oe_n_o(oen1), .mem_addr_o(ma1),
    .mem_dq_o(dqo1), .mem_dq_oe_o(dqoe1), .mem_dq_i(dqi1));

  sim_dram_model #(.T_RP(TRP), .T_CSR(TCSR)) m1 (
    .clk_i(clk), .arm_i(arm1), .ready_i(rdy1), .ras_n_i(ras1), .cas_n_i(cas1), .we_n_i(wen1),
    .oe_n_i(oen1), .addr_i(ma1), .dq_i(dqo1), .dq_oe_i(dqoe1), .dq_o(dqi1));

  // {we, row, col, wdata, expected read}
  localparam logic [30:0] VEC [8] = '{
    {1'b1, 11'd1, 11'd2, 4'hA, 4'h0},
    {1'b1, 11'd2, 11'd1, 4'h5, 4'h0},
    {1'b1, 11'd3, 11'd3, 4'hC, 4'h0},
    {1'b0, 11'd1, 11'd2, 4'h0, 4'hA},
    {1'b0, 11'd2, 11'd1, 4'h0, 4'h5},
    {1'b0, 11'd3, 11'd3, 4'h0, 4'hC},
    {1'b1, 11'd1, 11'd2, 4'h3, 4'h0},
    {1'b0, 11'd1, 11'd2, 4'h0, 4'h3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [21:0] ad, input logic [3:0] d,
                       output logic [3:0] q, output bit pulse_ok);
    int n;
    @(negedge clk);
    v = 1'b1; w = we; a = ad; wd = d;
    while (!rdy) @(negedge clk);
    @(negedge clk);
    v = 1'b0;
    q = 4'h0;
    pulse_ok = 1'b1;
    if (!we) begin
      n = 0;
      while (!rv && n < 50) begin @(negedge clk); n++; end
      q = rd;
      pulse_ok = rv;
      @(negedge clk);
      if (rv) pulse_ok = 1'b0;
    end
  endtask

  initial begin
    int rel, c0, c1, reads;
    logic [3:0] q;
    bit pok;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(ras && cas && wen && oen, "R1 strobes high in reset", {ras, cas, wen, oen}, 15);
    chk(!rdy, "R1 ready low in reset", rdy, 0);
    rst_n = 1'b1;
    rel = m0.cyc;
    @(negedge clk);
    chk(ras && cas && wen && oen, "R1 strobes high after reset", {ras, cas, wen, oen}, 15);
    chk(!rdy, "R1 ready low in pause", rdy, 0);
    while (!rdy) @(negedge clk);
    chk(m0.first_fall - rel >= PAUSE, "R1 pause length", m0.first_fall - rel, PAUSE);
    chk(m0.cbr_cnt == WAKE, "R2 wake cycles before ready", m0.cbr_cnt, WAKE);
    chk(m0.acc_cnt == 0, "R2 no access during wake", m0.acc_cnt, 0);
    arm = 1'b1;
    // vector table: R4 writes, R5/R10 reads
    for (int i = 0; i < 8; i++) begin
      do_op(VEC[i][30], VEC[i][29:8], VEC[i][7:4], q, pok);
      if (!VEC[i][30]) begin
        chk(q == VEC[i][3:0], "R5 R10 read data", q, VEC[i][3:0]);
        chk(pok, "R5 single valid pulse", pok, 1);
      end
    end
    chk(m0.wcs_err == 0, "R4 WE low before RAS fall", m0.wcs_err, 0);
    chk(m0.oe_err == 0, "R4 OE high in write", m0.oe_err, 0);
    // R8 refresh versus a request held valid across expiries
    repeat (3) @(negedge clk);
    c0 = m0.cbr_cnt;
    reads = 0;
    v = 1'b1; w = 1'b0; a = {11'd2, 11'd1};
    repeat (5 * RINT) begin
      @(negedge clk);
      if (rv) reads++;
    end
    v = 1'b0;
    c1 = m0.cbr_cnt - c0;
    repeat (30) @(negedge clk);
    chk(c1 >= 4 && c1 <= 6, "R8 refresh count under traffic", c1, 5);
    chk(reads > 50, "R8 host served under traffic", reads, 51);
    chk(m0.max_run <= 1, "R8 R9 no wake burst when deadline met", m0.max_run, 1);
    // R8 idle refresh rate
    c0 = m0.cbr_cnt;
    repeat (4 * RINT) @(negedge clk);
    c1 = m0.cbr_cnt - c0;
    chk(c1 >= 3 && c1 <= 5, "R8 idle refresh count", c1, 4);
    chk(m0.we_err == 0 && m1.we_err == 0, "R3 WE OE high at CBR", m0.we_err + m1.we_err, 0);
    chk(m0.trp_err == 0 && m1.trp_err == 0, "R6 precharge", m0.trp_err + m1.trp_err, 0);
    chk(m0.rdy_err == 0 && m1.rdy_err == 0, "R7 ready after precharge", m0.rdy_err + m1.rdy_err, 0);
    chk(m1.max_run >= WAKE, "R9 wake rerun after missed refresh", m1.max_run, WAKE);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule